// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator

Two independent pulse-width modulated outputs, programmed through a small word-addressed register bus. Each channel is set by one duty register and by its share of a control register common to both channels. The duty register holds a high-phase count in bits 31:16 and a low-phase count in bits 15:0. The control bits choose a tick source, a prescale ratio, a clock gate and an output gate. The four tick sources are single-cycle enable inputs in the block's one clock domain. A channel's counters advance only on qualified ticks of its chosen source, divided by its prescaler.

Each channel is a three-state machine. State IDLE_OFF drives the output low and holds the counters cleared. State PHASE_HI drives it high and PHASE_LO drives it low. The transitions are named as follows:
- START (IDLE_OFF to PHASE_HI, or to PHASE_LO when the high count is zero) fires when the output gate is set.
- FALL (PHASE_HI to PHASE_LO) fires when the high count is used up.
- WRAP fires at each period boundary. It reloads the counts and re-enters PHASE_HI, or PHASE_LO when the new high count is zero.
- STOP (any state to IDLE_OFF) fires when the output gate clears.

The counts are copied into working registers only on START and WRAP. A new duty written during a period therefore never cuts that period short.

Top module: `pwm_dual`

## Requirements
- R1: After reset all three registers read zero and both outputs are low.
- R2: Word offset 0x0 (channel A duty) and 0x4 (channel B duty) read back as written. Offset 0x8 (control) reads back the written value ANDed with 0x00FF_FFF3. Offset 0xC reads zero.
- R3: When the output-enable bit of a channel is 0, its output is low from the cycle after that bit is seen. Channel A uses control bit 0 and channel B uses bit 1.
- R4: When a channel is enabled with a nonzero high count, its output goes high in the cycle after the enable is written, with its counters cleared.
- R5: With a nonzero high count H and a nonzero low count L, the output is high for H prescaled ticks and then low for L prescaled ticks, repeating with period H+L.
- R6: The prescaler field P (bits 14:8 for A, 22:16 for B) makes each prescaled tick last P+1 qualified source ticks.
- R7: The source field (bits 5:4 for A, 7:6 for B) picks which bit of `src_tick` is counted. Other source bits have no effect.
- R8: When the clock-enable bit (bit 15 for A, bit 23 for B) is 0, the channel does not advance and its output holds its level.
- R9: A high count of zero gives a constant low output. A low count of zero with a nonzero high count gives a constant high output.
- R10: A duty register written while the channel runs takes effect only at the next period boundary.
- R11: Channel B follows R3 to R9 from its own fields, independently of channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_enable | input | 1 | Access phase qualifier; a write happens when sel, enable and write are all high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 1:0 must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_tick | input | 4 | One tick-enable per selectable source |
| pwm_out | output | 2 | Bit 0 channel A output, bit 1 channel B output |

## Verification
A register write lands at the clock edge of its access phase. The channel machine acts on it at the next edge, so an output's first new level appears one full cycle after the write edge. The bench skips exactly that one intermediate sample before it starts comparing. Read data is combinational, so reads are sampled 1 ns after the address is driven. After the start, each waveform is compared cycle by cycle at falling edges against a count model. The model allows high time × (prescale + 1) cycles of high, with the prescaled counting beginning on the START edge. A duty write issued one cycle after the enable lands on the START edge itself. The model therefore expects the old counts for one full period and the new ones from the following WRAP.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int NUM_CH = 2;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 7;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Control-register field positions; software depends on these.
    function automatic int sel_lsb(int ch);
        return 4 + SEL_W * ch;
    endfunction

    function automatic int pre_lsb(int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int clken_bit(int ch);
        return pre_lsb(ch) + PRE_W;
    endfunction

    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m[ch] = 1'b1;
            for (int b = 0; b < SEL_W; b++) m[sel_lsb(ch) + b] = 1'b1;
            for (int b = 0; b < PRE_W; b++) m[pre_lsb(ch) + b] = 1'b1;
            m[clken_bit(ch)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CW     = CNT_W,
    parameter int PW     = PRE_W,
    parameter int SW     = SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_i,
    input  logic                     enable_i,
    input  logic                     write_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [2*CW-1:0]          wdata_i,
    output logic [2*CW-1:0]          rdata_o,
    output logic [NUM_CH-1:0][2*CW-1:0] duty_o,
    output logic [NUM_CH-1:0]        out_en_o,
    output logic [NUM_CH-1:0]        clk_en_o,
    output logic [NUM_CH-1:0][SW-1:0] src_sel_o,
    output logic [NUM_CH-1:0][PW-1:0] pre_o
);
    localparam int DW = 2 * CW;
    localparam int IW = ADDR_W - 2;
    localparam logic [IW-1:0] IDX_CTRL = IW'(NUM_CH);
    localparam logic [DW-1:0] MASK = DW'(ctrl_mask());

    logic [NUM_CH-1:0][DW-1:0] duty_q;
    logic [DW-1:0]             ctrl_q;
    logic [IW-1:0]             idx;
    logic                      aligned;
    logic                      wr;

    assign idx     = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign wr      = sel_i && enable_i && write_i && aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (idx == IDX_CTRL) ctrl_q <= wdata_i & MASK;
            for (int c = 0; c < NUM_CH; c++)
                if (idx == IW'(c)) duty_q[c] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (idx == IDX_CTRL) rdata_o = ctrl_q;
            for (int c = 0; c < NUM_CH; c++)
                if (idx == IW'(c)) rdata_o = duty_q[c];
        end
    end

    assign duty_o = duty_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        assign out_en_o[c]  = ctrl_q[c];
        assign clk_en_o[c]  = ctrl_q[clken_bit(c)];
        assign src_sel_o[c] = ctrl_q[sel_lsb(c) +: SW];
        assign pre_o[c]     = ctrl_q[pre_lsb(c) +: PW];
    end

    // R2: unmapped control bits never appear on the read path
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && aligned && idx == IDX_CTRL) |-> ((rdata_o & ~MASK) == '0));
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [PW-1:0] pre_i,
    output logic          strobe_o
);
    logic [PW-1:0] pcnt_q;

    assign strobe_o = run_i && tick_i && (pcnt_q >= pre_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pcnt_q <= '0;
        else if (!run_i)  pcnt_q <= '0;
        else if (tick_i)  pcnt_q <= strobe_o ? '0 : pcnt_q + 1'b1;
    end

    // R8: without a qualified tick the divider does not move
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PW   = PRE_W,
    parameter int SW   = SEL_W,
    parameter int NSRC = 1 << SW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en_i,
    input  logic            clk_en_i,
    input  logic [SW-1:0]   src_sel_i,
    input  logic [PW-1:0]   pre_i,
    input  logic [CW-1:0]   hi_i,
    input  logic [CW-1:0]   lo_i,
    input  logic [NSRC-1:0] src_tick_i,
    output logic            pwm_o
);
    localparam int CW1 = CW + 1;

    phase_e        st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] hi_sh, lo_sh;
    logic          load;
    logic          tick, strobe, run;
    logic [CW1-1:0] cnt_nx;

    assign tick   = clk_en_i && src_tick_i[src_sel_i];
    assign run    = (st_q != PH_OFF);
    assign cnt_nx = {1'b0, cnt_q} + 1'b1;

    pwm_prescaler #(.PW(PW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick),
        .pre_i    (pre_i),
        .strobe_o (strobe)
    );

    // Next-state logic: START, FALL, WRAP, STOP
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        load  = 1'b0;
        unique case (st_q)
            PH_OFF: begin
                if (out_en_i) begin                              // START
                    load  = 1'b1;
                    st_d  = (hi_i != '0) ? PH_HIGH : PH_LOW;
                    cnt_d = '0;
                end
            end
            PH_HIGH: begin
                if (strobe) begin
                    if (cnt_nx >= {1'b0, hi_sh}) begin
                        cnt_d = '0;
                        if (lo_sh != '0) st_d = PH_LOW;          // FALL
                        else begin                               // WRAP
                            load = 1'b1;
                            st_d = (hi_i != '0) ? PH_HIGH : PH_LOW;
                        end
                    end else cnt_d = cnt_nx[CW-1:0];
                end
            end
            PH_LOW: begin
                if (strobe) begin
                    if (lo_sh == '0 || cnt_nx >= {1'b0, lo_sh}) begin  // WRAP
                        load  = 1'b1;
                        cnt_d = '0;
                        st_d  = (hi_i != '0) ? PH_HIGH : PH_LOW;
                    end else cnt_d = cnt_nx[CW-1:0];
                end
            end
            default: st_d = PH_OFF;
        endcase
        if (!out_en_i) begin                                     // STOP
            st_d  = PH_OFF;
            cnt_d = '0;
            load  = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_OFF;
            cnt_q <= '0;
            hi_sh <= '0;
            lo_sh <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (load) begin
                hi_sh <= hi_i;
                lo_sh <= lo_i;
            end
        end
    end

    // Output decode
    always_comb begin
        pwm_o = (st_q == PH_HIGH);
    end

    // R3: a cleared gate forces the output low next cycle
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> !pwm_o);
    // R4: enabling with a nonzero high count starts high, counters cleared
    p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_OFF && out_en_i && hi_i != '0) |=> (st_q == PH_HIGH && cnt_q == '0));
    // R5: the phase counter stays inside the high phase length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HIGH) |-> (cnt_q < hi_sh));
    // R9: the high phase is never entered with a zero high count
    p_high_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HIGH) |-> (hi_sh != '0));
    // R10: working counts change only at a period boundary
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != PH_OFF && !strobe) |=> ($stable(hi_sh) && $stable(lo_sh)));
endmodule

// File: rtl/pwm_dual.sv
`timescale 1ns/1ps
module pwm_dual
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CW     = CNT_W,
    parameter int PW     = PRE_W,
    parameter int SW     = SEL_W,
    localparam int DW    = 2 * CW,
    localparam int NSRC  = 1 << SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NSRC-1:0]   src_tick,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][DW-1:0] duty;
    logic [NUM_CH-1:0]         out_en, clk_en;
    logic [NUM_CH-1:0][SW-1:0] src_sel;
    logic [NUM_CH-1:0][PW-1:0] pre;

    pwm_regs #(.ADDR_W(ADDR_W), .CW(CW), .PW(PW), .SW(SW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .enable_i  (bus_enable),
        .write_i   (bus_write),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .duty_o    (duty),
        .out_en_o  (out_en),
        .clk_en_o  (clk_en),
        .src_sel_o (src_sel),
        .pre_o     (pre)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.CW(CW), .PW(PW), .SW(SW), .NSRC(NSRC)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .out_en_i   (out_en[c]),
            .clk_en_i   (clk_en[c]),
            .src_sel_i  (src_sel[c]),
            .pre_i      (pre[c]),
            .hi_i       (duty[c][DW-1:CW]),
            .lo_i       (duty[c][CW-1:0]),
            .src_tick_i (src_tick),
            .pwm_o      (pwm_out[c])
        );
    end
endmodule

// File: tb/tb_pwm_dual.sv
`timescale 1ns/1ps
module tb_pwm_dual;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = 4'hF;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pwm_dual dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctl_a(bit en, bit ce, int sel, int pre);
        return 32'(en) | (32'(sel) << 4) | (32'(pre) << 8) | (32'(ce) << 15);
    endfunction
    function automatic logic [31:0] ctl_b(bit en, bit ce, int sel, int pre);
        return (32'(en) << 1) | (32'(sel) << 6) | (32'(pre) << 16) | (32'(ce) << 23);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_enable = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_enable = 0; bus_write = 0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1; bus_addr = a; #1;
        chk(req, bus_rdata, exp);
        bus_sel = 0;
    endtask

    // Compare n cycles of one output against the count model; skip the
    // sample between the enabling write edge and the START edge.
    task automatic wave(string req, int ch, int n, int hi, int lo, int pre);
        int unit = pre + 1;
        int per  = (hi + lo) * unit;
        int bad = 0;
        logic e = 0, a = 0;
        @(negedge clk);
        for (int t = 0; t < n; t++) begin
            logic ex;
            @(negedge clk);
            if (hi == 0) ex = 0;
            else if (lo == 0) ex = 1;
            else ex = ((t % per) < hi * unit);
            if (pwm_out[ch] !== ex && bad == 0) begin bad = 1; a = pwm_out[ch]; e = ex; end
        end
        chk(req, {31'b0, a}, {31'b0, e});
    endtask

    task automatic steady(string req, int ch, int n, logic lvl);
        int bad = 0;
        logic a = lvl;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl && bad == 0) begin bad = 1; a = pwm_out[ch]; end
        end
        chk(req, {31'b0, a}, {31'b0, lvl});
    endtask

    task automatic t_reset();
        chk("R1 outputs", {30'b0, pwm_out}, 32'h0);
        rd_chk("R1 dutyA", 4'h0, 32'h0);
        rd_chk("R1 dutyB", 4'h4, 32'h0);
        rd_chk("R1 ctrl", 4'h8, 32'h0);
    endtask

    task automatic t_regs();
        wr(4'h0, 32'h1234_5678); rd_chk("R2 dutyA", 4'h0, 32'h1234_5678);
        wr(4'h4, 32'h9ABC_DEF0); rd_chk("R2 dutyB", 4'h4, 32'h9ABC_DEF0);
        wr(4'h8, 32'hFFFF_FFFF); rd_chk("R2 ctrl mask", 4'h8, 32'h00FF_FFF3);
        rd_chk("R2 hole", 4'hC, 32'h0);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_basic();
        src_tick = 4'hF;
        wr(4'h0, {16'd3, 16'd2});
        wr(4'h8, ctl_a(1, 1, 0, 0));
        wave("R4 R5 hi3 lo2", 0, 30, 3, 2, 0);
        chk("R11 B idle", {31'b0, pwm_out[1]}, 32'h0);
        wr(4'h8, 0);
    endtask

    task automatic t_prescale();
        wr(4'h0, {16'd2, 16'd1});
        wr(4'h8, ctl_a(1, 1, 0, 2));
        wave("R6 pre2", 0, 36, 2, 1, 2);
        wr(4'h8, 0);
    endtask

    task automatic t_select();
        src_tick = 4'b0100;
        wr(4'h0, {16'd2, 16'd2});
        wr(4'h8, ctl_a(1, 1, 2, 0));
        wave("R7 sel2 counts", 0, 16, 2, 2, 0);
        wr(4'h8, 0);
        wr(4'h8, ctl_a(1, 1, 1, 0));
        @(negedge clk);
        steady("R7 sel1 ignored", 0, 12, 1'b1);
        wr(4'h8, 0);
        src_tick = 4'hF;
    endtask

    task automatic t_clkgate();
        wr(4'h0, {16'd2, 16'd2});
        wr(4'h8, ctl_a(1, 0, 0, 0));
        @(negedge clk);
        steady("R8 gated holds", 0, 12, 1'b1);
        wr(4'h8, 0);
    endtask

    task automatic t_extremes();
        wr(4'h0, {16'd0, 16'd5});
        wr(4'h8, ctl_a(1, 1, 0, 0));
        @(negedge clk);
        steady("R9 zero high", 0, 20, 1'b0);
        wr(4'h8, 0);
        wr(4'h0, {16'd4, 16'd0});
        wr(4'h8, ctl_a(1, 1, 0, 0));
        @(negedge clk);
        steady("R9 zero low", 0, 20, 1'b1);
        wr(4'h8, 0);
    endtask

    task automatic t_update();
        int bad = 0;
        logic a = 0, e = 0;
        wr(4'h0, {16'd2, 16'd2});
        wr(4'h8, ctl_a(1, 1, 0, 0));
        wr(4'h0, {16'd5, 16'd1});   // lands on the START edge
        for (int t = 0; t < 22; t++) begin
            logic ex;
            @(negedge clk);
            ex = (t < 4) ? (t < 2) : (((t - 4) % 6) < 5);
            if (pwm_out[0] !== ex && bad == 0) begin bad = 1; a = pwm_out[0]; e = ex; end
        end
        chk("R10 boundary update", {31'b0, a}, {31'b0, e});
        wr(4'h8, 0);
    endtask

    task automatic t_stop();
        wr(4'h0, {16'd3, 16'd3});
        wr(4'h8, ctl_a(1, 1, 0, 0));
        repeat (4) @(negedge clk);
        wr(4'h8, 0);
        @(negedge clk);
        steady("R3 stop low", 0, 8, 1'b0);
        wr(4'h8, ctl_a(1, 1, 0, 0));
        wave("R4 restart high", 0, 18, 3, 3, 0);
        wr(4'h8, 0);
    endtask

    task automatic t_chan_b();
        wr(4'h4, {16'd3, 16'd2});
        wr(4'h8, ctl_b(1, 1, 3, 1));
        wave("R11 B wave", 1, 40, 3, 2, 1);
        chk("R11 A idle", {31'b0, pwm_out[0]}, 32'h0);
        wr(4'h8, 0);
        @(negedge clk); @(negedge clk);
        chk("R3 B off", {31'b0, pwm_out[1]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_prescale();
        t_select();
        t_clkgate();
        t_extremes();
        t_update();
        t_stop();
        t_chan_b();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule